// File: doc/BRIEF.md
# Delay-slot macro sequencer

This block is the program counter and control sequencer of a small macro processor. It fetches 32-bit instruction words from a local instruction memory and issues them one per cycle to the datapath. The datapath itself (ALU, register file, write-back) sits outside this block. On a start pulse the sequencer spends one initialisation cycle. In that cycle it tells the register file to clear every register and the carry, and to load the head of the parameter FIFO into register 1. It pops that entry, so later parameter fetches resume at the second entry. It then steps through the program from word 0.

Control flow follows delay-slot rules. A conditional branch tests the register selected by the instruction's source-A field. When it is taken, the branch executes the next sequential word as a delay slot and then jumps, unless its annul bit asks for an immediate jump. An exit flag ends the program after one further delay-slot word. The sequencer flags two illegal cases and stops on either: a branch found in a delay slot, and a fetch at or beyond the loaded program length. When the exit slot retires, a one-cycle done pulse also reports whether parameters were left unread.

Top module: `macro_seq`

## Requirements
- R1: One cycle after start is sampled while idle, the block spends exactly one cycle with busy, regs_clear, r1_load and param_pop all high. It then fetches word 0.
- R2: Words without branch or exit are issued one per cycle at consecutive addresses. issue_valid is high, imem_addr gives the address and issue_word gives the fetched word.
- R3: Opcode field bits [2:0] = 7 marks a branch. Bit 4 selects its condition: 0 means taken when reg_a_val is zero, 1 means taken when reg_a_val is non-zero. reg_a_sel carries bits [13:11] of the current word. A branch that is not taken continues sequentially.
- R4: The branch target is the branch's own word address plus the signed 18-bit immediate in bits [31:14], counted in words. Both forward and backward targets are supported.
- R5: A taken branch with annul bit 5 clear issues the word after the branch as a delay slot, then continues at the target.
- R6: A taken branch with annul bit 5 set continues at the target in the next cycle, with no delay slot.
- R7: A non-branch word, or a branch that is not taken, with exit bit 7 set is followed by exactly one more issued word. The cycle after that word, done is high for one cycle and busy is low.
- R8: An exit bit on a word executing in a delay slot has no effect: execution continues at the branch target.
- R9: A branch word reached in a delay slot is not issued. The next cycle err_slot pulses for one cycle, busy drops and no done follows.
- R10: A fetch at an address not below prog_len is not issued. The next cycle err_overrun pulses for one cycle, busy drops and no done follows.
- R11: In the done cycle, params_left is high if the parameter FIFO was not empty when the exit slot issued, and low if it was empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a macro run (ignored while busy) |
| prog_len | input | PC_W+1 | Number of loaded instruction words |
| imem_addr | output | PC_W | Instruction memory word address |
| imem_rdata | input | 32 | Instruction word at imem_addr (same cycle) |
| reg_a_sel | output | 3 | Source-A register index of the current word |
| reg_a_val | input | 32 | Value of the register named by reg_a_sel |
| param_empty | input | 1 | Parameter FIFO is empty |
| param_pop | output | 1 | Pop the head of the parameter FIFO (initialisation cycle) |
| regs_clear | output | 1 | Clear all registers and the carry |
| r1_load | output | 1 | Load the popped parameter into register 1 |
| issue_valid | output | 1 | A word is issued to the datapath this cycle |
| issue_word | output | 32 | The issued word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the exit slot retires |
| params_left | output | 1 | Valid with done: unread parameters remained |
| err_slot | output | 1 | One-cycle pulse: branch found in a delay slot |
| err_overrun | output | 1 | One-cycle pulse: fetch beyond the program length |

## Verification
A branch template is swept over both condition polarities, zero and non-zero register values, annul set and clear, and three forward offsets. The issued address trace separates taken from not-taken, slot from no slot, and correct from wrong target arithmetic. The non-zero test value has only high bits set, so a zero test that looks at a narrow slice is caught. Directed programs add a backward target, an exit inside a delay slot, a branch inside a slot, an overrun, and a non-empty FIFO at exit. Each of these yields a distinct trace or termination kind.

// File: rtl/macro_seq_pkg.sv
package macro_seq_pkg;

    localparam int WORD_W    = 32;
    localparam int RSEL_W    = 3;
    localparam int IMM_W     = 18;
    localparam int OPC_LSB   = 0;
    localparam int COND_BIT  = 4;
    localparam int ANNUL_BIT = 5;
    localparam int EXIT_BIT  = 7;
    localparam int SRCA_LSB  = 11;
    localparam int IMM_LSB   = 14;

    localparam logic [2:0] OPC_BRANCH = 3'd7;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_INIT = 2'd1,
        SQ_RUN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] raw;
        logic              is_branch;
        logic              cond_nz;
        logic              annul;
        logic              exit_flag;
        logic [RSEL_W-1:0] src_a;
        logic [IMM_W-1:0]  imm;
    } word_fields_t;

    function automatic word_fields_t split_word(input logic [WORD_W-1:0] w);
        word_fields_t f;
        f.raw       = w;
        f.is_branch = (w[OPC_LSB +: 3] == OPC_BRANCH);
        f.cond_nz   = w[COND_BIT];
        f.annul     = w[ANNUL_BIT];
        f.exit_flag = w[EXIT_BIT];
        f.src_a     = w[SRCA_LSB +: RSEL_W];
        f.imm       = w[IMM_LSB +: IMM_W];
        return f;
    endfunction

endpackage

// File: rtl/macro_seq_decode.sv
module macro_seq_decode
    import macro_seq_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    output word_fields_t      fields
);
    always_comb begin
        fields = split_word(word_in);
    end
endmodule

// File: rtl/macro_seq_branch.sv
module macro_seq_branch
    import macro_seq_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic [PC_W-1:0]   pc,
    input  word_fields_t      fields,
    input  logic [WORD_W-1:0] reg_a_val,
    output logic              taken,
    output logic [PC_W-1:0]   target
);
    localparam int EXT_W = (PC_W > IMM_W) ? PC_W : IMM_W;

    logic              a_is_zero;
    logic [EXT_W-1:0]  imm_ext;

    always_comb begin
        a_is_zero = (reg_a_val == '0);
        taken     = fields.is_branch & (fields.cond_nz ? !a_is_zero : a_is_zero);
        imm_ext   = EXT_W'($signed(fields.imm));
        target    = pc + imm_ext[PC_W-1:0];
    end
endmodule

// File: rtl/macro_seq_ctrl.sv
module macro_seq_ctrl
    import macro_seq_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [PC_W:0]   prog_len,
    input  word_fields_t    fields,
    input  logic            br_taken,
    input  logic [PC_W-1:0] br_target,
    input  logic            param_empty,
    output logic [PC_W-1:0] pc,
    output logic            issue_valid,
    output logic            param_pop,
    output logic            regs_clear,
    output logic            r1_load,
    output logic            busy,
    output logic            done,
    output logic            params_left,
    output logic            err_slot,
    output logic            err_overrun
);
    seq_state_e      st_q, st_d;
    logic [PC_W-1:0] pc_q, pc_d;
    logic            in_slot_q, in_slot_d;
    logic            slot_exit_q, slot_exit_d;
    logic [PC_W-1:0] slot_tgt_q, slot_tgt_d;
    logic            done_q, done_d;
    logic            left_q, left_d;
    logic            eslot_q, eslot_d;
    logic            eovr_q, eovr_d;
    logic            fetch_ok, slot_bad, run;

    always_comb begin
        run       = (st_q == SQ_RUN);
        fetch_ok  = ({1'b0, pc_q} < prog_len);
        slot_bad  = in_slot_q & fields.is_branch;

        st_d        = st_q;
        pc_d        = pc_q;
        in_slot_d   = in_slot_q;
        slot_exit_d = slot_exit_q;
        slot_tgt_d  = slot_tgt_q;
        done_d      = 1'b0;
        left_d      = 1'b0;
        eslot_d     = 1'b0;
        eovr_d      = 1'b0;

        unique case (st_q)
            SQ_IDLE: begin
                if (start) begin
                    st_d = SQ_INIT;
                end
            end
            SQ_INIT: begin
                st_d        = SQ_RUN;
                pc_d        = '0;
                in_slot_d   = 1'b0;
                slot_exit_d = 1'b0;
            end
            SQ_RUN: begin
                if (!fetch_ok) begin
                    eovr_d = 1'b1;
                    st_d   = SQ_IDLE;
                end else if (slot_bad) begin
                    eslot_d = 1'b1;
                    st_d    = SQ_IDLE;
                end else if (in_slot_q) begin
                    in_slot_d = 1'b0;
                    if (slot_exit_q) begin
                        done_d = 1'b1;
                        left_d = !param_empty;
                        st_d   = SQ_IDLE;
                    end else begin
                        pc_d = slot_tgt_q;
                    end
                end else if (br_taken) begin
                    if (fields.annul) begin
                        pc_d = br_target;
                    end else begin
                        in_slot_d   = 1'b1;
                        slot_exit_d = 1'b0;
                        slot_tgt_d  = br_target;
                        pc_d        = pc_q + 1'b1;
                    end
                end else if (fields.exit_flag) begin
                    in_slot_d   = 1'b1;
                    slot_exit_d = 1'b1;
                    pc_d        = pc_q + 1'b1;
                end else begin
                    pc_d = pc_q + 1'b1;
                end
            end
            default: st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= SQ_IDLE;
            pc_q        <= '0;
            in_slot_q   <= 1'b0;
            slot_exit_q <= 1'b0;
            slot_tgt_q  <= '0;
            done_q      <= 1'b0;
            left_q      <= 1'b0;
            eslot_q     <= 1'b0;
            eovr_q      <= 1'b0;
        end else begin
            st_q        <= st_d;
            pc_q        <= pc_d;
            in_slot_q   <= in_slot_d;
            slot_exit_q <= slot_exit_d;
            slot_tgt_q  <= slot_tgt_d;
            done_q      <= done_d;
            left_q      <= left_d;
            eslot_q     <= eslot_d;
            eovr_q      <= eovr_d;
        end
    end

    assign pc          = pc_q;
    assign issue_valid = run & fetch_ok & !slot_bad;
    assign param_pop   = (st_q == SQ_INIT);
    assign regs_clear  = (st_q == SQ_INIT);
    assign r1_load     = (st_q == SQ_INIT);
    assign busy        = (st_q != SQ_IDLE);
    assign done        = done_q;
    assign params_left = left_q;
    assign err_slot    = eslot_q;
    assign err_overrun = eovr_q;

    // R1
    init_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (regs_clear && r1_load && param_pop));

    // R2
    issue_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> (busy && ({1'b0, pc} < prog_len)));

    // R6
    annul_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !in_slot_q && br_taken && fields.annul) |=> (pc == $past(br_target)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9
    slot_branch_chk: assert property (@(posedge clk) disable iff (rst)
        err_slot |-> ($past(in_slot_q) && !busy && !done));

    // R10
    overrun_chk: assert property (@(posedge clk) disable iff (rst)
        err_overrun |-> ({1'b0, $past(pc)} >= $past(prog_len)));

endmodule

// File: rtl/macro_seq.sv
module macro_seq
    import macro_seq_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PC_W:0]     prog_len,
    output logic [PC_W-1:0]   imem_addr,
    input  logic [31:0]       imem_rdata,
    output logic [2:0]        reg_a_sel,
    input  logic [31:0]       reg_a_val,
    input  logic              param_empty,
    output logic              param_pop,
    output logic              regs_clear,
    output logic              r1_load,
    output logic              issue_valid,
    output logic [31:0]       issue_word,
    output logic              busy,
    output logic              done,
    output logic              params_left,
    output logic              err_slot,
    output logic              err_overrun
);
    word_fields_t    fields;
    logic            br_taken;
    logic [PC_W-1:0] br_target;
    logic [PC_W-1:0] pc;

    macro_seq_decode u_dec (
        .word_in (imem_rdata),
        .fields  (fields)
    );

    macro_seq_branch #(.PC_W(PC_W)) u_br (
        .pc        (pc),
        .fields    (fields),
        .reg_a_val (reg_a_val),
        .taken     (br_taken),
        .target    (br_target)
    );

    macro_seq_ctrl #(.PC_W(PC_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .prog_len    (prog_len),
        .fields      (fields),
        .br_taken    (br_taken),
        .br_target   (br_target),
        .param_empty (param_empty),
        .pc          (pc),
        .issue_valid (issue_valid),
        .param_pop   (param_pop),
        .regs_clear  (regs_clear),
        .r1_load     (r1_load),
        .busy        (busy),
        .done        (done),
        .params_left (params_left),
        .err_slot    (err_slot),
        .err_overrun (err_overrun)
    );

    assign imem_addr  = pc;
    assign reg_a_sel  = fields.src_a;
    assign issue_word = fields.raw;

endmodule

// File: tb/macro_seq_test.sv
module macro_seq_test;
    localparam int PC_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [PC_W:0] prog_len = 9'd16;
    logic [PC_W-1:0] imem_addr;
    logic [31:0] imem_rdata;
    logic [2:0] reg_a_sel;
    logic [31:0] reg_a_val;
    logic param_empty = 1'b1;
    logic param_pop, regs_clear, r1_load, issue_valid, busy, done, params_left;
    logic err_slot, err_overrun;
    logic [31:0] issue_word;

    logic [31:0] mem [16];
    logic [31:0] rfile [8];

    int checks = 0;
    int errors = 0;
    int trace [64];
    int tn;
    int expv [64];
    int en;
    int kind;
    logic left_seen;

    always #10 clk = ~clk;

    assign imem_rdata = mem[imem_addr[3:0]];
    assign reg_a_val  = rfile[reg_a_sel];

    macro_seq #(.PC_W(PC_W)) uut (
        .clk(clk), .rst(rst), .start(start), .prog_len(prog_len),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .reg_a_sel(reg_a_sel), .reg_a_val(reg_a_val),
        .param_empty(param_empty), .param_pop(param_pop),
        .regs_clear(regs_clear), .r1_load(r1_load),
        .issue_valid(issue_valid), .issue_word(issue_word),
        .busy(busy), .done(done), .params_left(params_left),
        .err_slot(err_slot), .err_overrun(err_overrun)
    );

    function automatic logic [31:0] br(input int cnd, input int ann, input int ex,
                                       input int src, input int off);
        logic [17:0] o;
        o = 18'(off);
        return {o, 3'(src), 3'd0, 1'(ex), 1'b0, 1'(ann), 1'(cnd), 1'b0, 3'd7};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 16; i++) mem[i] = 32'h0;
        for (int i = 0; i < 8; i++) rfile[i] = 32'h0;
    endtask

    task automatic push_exp(input int a);
        expv[en] = a;
        en++;
    endtask

    task automatic run_prog();
        tn = 0;
        kind = 3;
        left_seen = 1'b0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (issue_valid && tn < 64) begin
                trace[tn] = int'(imem_addr);
                tn++;
            end
            if (done) begin kind = 0; left_seen = params_left; break; end
            if (err_slot) begin kind = 1; break; end
            if (err_overrun) begin kind = 2; break; end
        end
        if (kind == 3) begin
            chk(1'b0, "R7", "run timeout", 3, 0);
        end
    endtask

    task automatic cmp_trace(input string req);
        int bad;
        bad = -1;
        if (tn != en) begin
            chk(1'b0, req, "trace length", tn, en);
        end else begin
            for (int i = 0; i < en; i++) begin
                if (bad < 0 && trace[i] != expv[i]) bad = i;
            end
            if (bad >= 0) chk(1'b0, req, "trace address", trace[bad], expv[bad]);
            else chk(1'b1, req, "trace", 0, 0);
        end
    endtask

    initial begin
        #4000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !issue_valid && !err_slot && !err_overrun,
            "R1", "reset idle", int'(busy), 0);

        // R1: initialisation cycle
        mem[2] = 32'h80;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy && regs_clear && r1_load && param_pop && !issue_valid,
            "R1", "init cycle", int'(regs_clear && r1_load && param_pop), 1);
        @(negedge clk);
        chk(issue_valid && imem_addr == 0 && !param_pop, "R1", "first fetch",
            int'(imem_addr), 0);
        for (int c = 0; c < 5; c++) @(negedge clk);

        // R2 R7: straight line with exit at 2
        run_prog();
        en = 0;
        for (int a = 0; a <= 3; a++) push_exp(a);
        cmp_trace("R2");
        chk(kind == 0, "R7", "done after exit slot", kind, 0);
        @(negedge clk);
        chk(!done && !busy, "R7", "done one cycle", int'(done), 0);

        // R3 R4 R5 R6 R11: branch sweep
        for (int cnd = 0; cnd < 2; cnd++) begin
            for (int zv = 0; zv < 2; zv++) begin
                for (int ann = 0; ann < 2; ann++) begin
                    for (int oi = 0; oi < 3; oi++) begin
                        int off, tgt;
                        bit tk;
                        clear_mem();
                        off = 2 + 2 * oi;
                        tgt = 3 + off;
                        rfile[1] = zv ? 32'h0 : 32'h1234_0000;
                        mem[3] = br(cnd, ann, 0, 1, off);
                        mem[12] = 32'h80;
                        tk = cnd ? (zv == 0) : (zv == 1);
                        en = 0;
                        for (int a = 0; a <= 3; a++) push_exp(a);
                        if (tk) begin
                            if (ann == 0) push_exp(4);
                            for (int a = tgt; a <= 13; a++) push_exp(a);
                        end else begin
                            for (int a = 4; a <= 13; a++) push_exp(a);
                        end
                        run_prog();
                        if (!tk) cmp_trace("R3");
                        else if (ann != 0) cmp_trace("R6");
                        else cmp_trace("R5");
                        chk(kind == 0, "R4", "sweep termination", kind, 0);
                        chk(left_seen == 1'b0, "R11", "params_left empty", int'(left_seen), 0);
                    end
                end
            end
        end

        // R4: backward target
        clear_mem();
        mem[0] = br(0, 1, 0, 0, 5);
        mem[6] = br(0, 1, 0, 0, -4);
        mem[2] = 32'h80;
        en = 0;
        push_exp(0); push_exp(5); push_exp(6); push_exp(2); push_exp(3);
        run_prog();
        cmp_trace("R4");

        // R8: exit flag in a delay slot ignored
        clear_mem();
        mem[0] = br(0, 0, 0, 0, 4);
        mem[1] = 32'h80;
        mem[5] = 32'h80;
        en = 0;
        push_exp(0); push_exp(1); push_exp(4); push_exp(5); push_exp(6);
        run_prog();
        cmp_trace("R8");
        chk(kind == 0, "R8", "done kind", kind, 0);

        // R9: branch inside exit slot
        clear_mem();
        mem[0] = 32'h80;
        mem[1] = br(1, 0, 0, 0, 3);
        en = 0;
        push_exp(0);
        run_prog();
        cmp_trace("R9");
        chk(kind == 1, "R9", "slot error after exit", kind, 1);
        @(negedge clk);
        chk(!err_slot && !busy, "R9", "error pulse one cycle", int'(err_slot), 0);

        // R9: branch inside branch slot
        clear_mem();
        mem[0] = br(0, 0, 0, 0, 5);
        mem[1] = br(0, 1, 0, 0, 2);
        en = 0;
        push_exp(0);
        run_prog();
        cmp_trace("R9");
        chk(kind == 1, "R9", "slot error after branch", kind, 1);

        // R10: overrun
        clear_mem();
        prog_len = 9'd3;
        en = 0;
        push_exp(0); push_exp(1); push_exp(2);
        run_prog();
        cmp_trace("R10");
        chk(kind == 2, "R10", "overrun kind", kind, 2);
        @(negedge clk);
        chk(!err_overrun && !busy && !done, "R10", "overrun pulse", int'(err_overrun), 0);
        prog_len = 9'd16;

        // R11: parameters left over
        clear_mem();
        mem[1] = 32'h80;
        param_empty = 1'b0;
        run_prog();
        chk(kind == 0 && left_seen == 1'b1, "R11", "params_left set", int'(left_seen), 1);
        param_empty = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule